// File: doc/BRIEF.md
# GPIO Register File with Change Interrupts

This block owns a bank of general-purpose pins and presents them to a host as a small register file. The host reaches it through a simple strobe bus: an address, a write strobe with write data, and a read strobe with read data that is valid in the same cycle. Through this bus the host sets each pin's direction and the level that output pins drive. It also chooses which input pins may interrupt, and it picks one of two interrupt behaviours. The pin pads themselves stay outside the block. The block supplies an output level and an output enable for every pin, and it receives the pad level back on its pin inputs.

Before any compare, the pin inputs pass through a synchronizer. Each armed input, meaning one that is enabled for interrupts and set as an input, is compared against a reference level. The interrupt output is meant to drive the enable of an open-drain pad, so a high level pulls the shared line low. In live mode, a pin that returns to its reference level withdraws its request. In latched mode, the pin-state register holds the level that caused the change, and the request stays until the host reads that register. Reading the pin-state register takes new reference levels, and so does writing the direction register. A software reset bit in the control register returns the block to its reset state.

Top module: `gpio_change_irq`

## Requirements
- R1: After reset, and with no writes since, all pins are inputs (pin_oe all 0), irq_oe is 0, and the direction register (address 0x0A), the interrupt-enable register (0x0C) and the control register (0x0E) all read 0.
- R2: Writing the direction register at 0x0A sets pin_oe from the cycle after the write strobe. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. The register reads back the value written.
- R3: Writing the pin-state register at 0x0B sets pin_out from the cycle after the strobe. Reading 0x0B returns, for each pin, the driven level when that pin is an output and the synchronized pad level when it is an input.
- R4: In live mode (control bit 0 = 0), a change on an input whose interrupt-enable bit is 1 drives irq_oe to 1. If that input returns to its reference level before any read of 0x0B, irq_oe returns to 0.
- R5: In live mode, a read strobe on 0x0B returns the current pin levels, makes them the new reference, and releases irq_oe. irq_oe stays 0 while the pins do not change again.
- R6: A change on an input whose interrupt-enable bit is 0, or on a pin configured as an output, never drives irq_oe to 1.
- R7: In latched mode (control bit 0 = 1), the first change on an armed input captures the new level into that pin's bit of 0x0B. irq_oe stays 1 even if the pin reverts. The next read of 0x0B returns the captured level and releases irq_oe, and the read after that returns the live level.
- R8: A write to the direction register releases any pending pin interrupt, whatever value is written.
- R9: A write to 0x0E with bit 3 = 1 clears the direction, pin-output, interrupt-enable and control registers and releases irq_oe. Bit 3 always reads back as 0.
- R10: Reserved addresses (every address other than 0x0A, 0x0B, 0x0C and 0x0E, including 0x0D) read as 0, and writes to them change no register. Control bits other than bit 0 read as 0.
- R11: A level change on pin_in appears in a read of 0x0B after exactly SYNC_STAGES rising clock edges, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| wr_data | input | NPINS | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; starts the side effects of a read |
| rd_data | output | NPINS | Read data for reg_addr, combinational |
| pin_in | input | NPINS | Levels seen at the pads |
| pin_out | output | NPINS | Levels driven by output pins |
| pin_oe | output | NPINS | Per-pin output enable |
| irq_oe | output | 1 | Enable of the open-drain interrupt pad (1 pulls the line low) |

## Verification
The bench builds the block with its default values: eight pins, a four-bit address and a two-stage synchronizer. With these values, every address in the map and every reserved address is inside the address space. The control bits at positions 0 and 3 are also within the data width. With two synchronizer stages, the bench can see exactly when a pad change becomes visible, and it can time the interrupt edges in both live and latched mode against a known delay.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam logic [7:0] ADR_DIR = 8'h0A;
    localparam logic [7:0] ADR_PIN = 8'h0B;
    localparam logic [7:0] ADR_IEN = 8'h0C;
    localparam logic [7:0] ADR_CTL = 8'h0E;

    localparam int CTL_LATCH_BIT = 0;
    localparam int CTL_SRST_BIT  = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_PIN,
        SEL_IEN,
        SEL_CTL
    } reg_sel_e;

    typedef struct packed {
        logic wr_dir;
        logic wr_pin;
        logic wr_ien;
        logic wr_ctl;
        logic rd_pin;
        logic srst;
    } host_ops_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        reg_sel_e s;
        case (a)
            ADR_DIR: s = SEL_DIR;
            ADR_PIN: s = SEL_PIN;
            ADR_IEN: s = SEL_IEN;
            ADR_CTL: s = SEL_CTL;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output reg_sel_e          sel,
    output host_ops_t         ops,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  ien_q,
    output logic              latch_q
);
    always_comb begin
        sel        = decode_addr(8'(addr));
        ops        = '0;
        ops.wr_dir = wr_en && (sel == SEL_DIR);
        ops.wr_pin = wr_en && (sel == SEL_PIN);
        ops.wr_ien = wr_en && (sel == SEL_IEN);
        ops.wr_ctl = wr_en && (sel == SEL_CTL);
        ops.rd_pin = rd_en && (sel == SEL_PIN);
        ops.srst   = ops.wr_ctl && wdata[CTL_SRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || ops.srst) begin
            dir_q   <= '0;
            out_q   <= '0;
            ien_q   <= '0;
            latch_q <= 1'b0;
        end else begin
            if (ops.wr_dir) dir_q   <= wdata;
            if (ops.wr_pin) out_q   <= wdata;
            if (ops.wr_ien) ien_q   <= wdata;
            if (ops.wr_ctl) latch_q <= wdata[CTL_LATCH_BIT];
        end
    end
endmodule

// File: rtl/gpx_change.sv
module gpx_change #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NPINS-1:0] pin_s,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] ien_q,
    input  logic             latch_q,
    input  logic             rearm,
    output logic [NPINS-1:0] cap_valid,
    output logic [NPINS-1:0] cap_val,
    output logic [NPINS-1:0] pend_vec,
    output logic             irq_oe
);
    logic [NPINS-1:0] ref_q;
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] chg;

    assign armed = ien_q & ~dir_q;
    assign chg   = (pin_s ^ ref_q) & armed;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        logic r_ref, r_cv, r_cval;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                r_ref  <= 1'b0;
                r_cv   <= 1'b0;
                r_cval <= 1'b0;
            end else begin
                // unarmed pins keep tracking, so arming never sees a stale level
                if (rearm || !armed[i]) r_ref <= pin_s[i];
                if (rearm || !latch_q || !armed[i]) begin
                    r_cv <= 1'b0;
                end else if (chg[i] && !r_cv) begin
                    r_cv   <= 1'b1;
                    r_cval <= pin_s[i];
                end
            end
        end
        assign ref_q[i]     = r_ref;
        assign cap_valid[i] = r_cv;
        assign cap_val[i]   = r_cval;
    end

    assign pend_vec = latch_q ? (cap_valid & armed) : chg;

    always_ff @(posedge clk) begin
        if (rst || clr) irq_oe <= 1'b0;
        else            irq_oe <= |pend_vec;
    end
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
    import gpx_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_oe
);
    reg_sel_e         sel;
    host_ops_t        ops;
    logic [NPINS-1:0] dir_q, out_q, ien_q;
    logic             latch_q;
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] cap_valid, cap_val, pend_vec;
    logic [NPINS-1:0] pin_view;

    gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    gpx_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wdata   (wr_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel     (sel),
        .ops     (ops),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .latch_q (latch_q)
    );

    gpx_change #(.NPINS(NPINS)) u_chg (
        .clk       (clk),
        .rst       (rst),
        .clr       (ops.srst),
        .pin_s     (pin_s),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .latch_q   (latch_q),
        .rearm     (ops.rd_pin | ops.wr_dir),
        .cap_valid (cap_valid),
        .cap_val   (cap_val),
        .pend_vec  (pend_vec),
        .irq_oe    (irq_oe)
    );

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (dir_q[i])          pin_view[i] = out_q[i];
            else if (cap_valid[i]) pin_view[i] = cap_val[i];
            else                   pin_view[i] = pin_s[i];
        end
        rd_data = '0;
        case (sel)
            SEL_DIR: rd_data = dir_q;
            SEL_PIN: rd_data = pin_view;
            SEL_IEN: rd_data = ien_q;
            SEL_CTL: rd_data[CTL_LATCH_BIT] = latch_q;
            default: rd_data = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_change_irq_chk.sv
module gpio_change_irq_chk
    import gpx_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq_oe,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  ien_q,
    input logic              latch_q,
    input logic [NPINS-1:0]  pin_s,
    input logic [NPINS-1:0]  pend_vec
);
    logic w_dir, w_pin, w_srst, r_pin;
    assign w_dir  = wr_en && (8'(reg_addr) == ADR_DIR);
    assign w_pin  = wr_en && (8'(reg_addr) == ADR_PIN);
    assign w_srst = wr_en && (8'(reg_addr) == ADR_CTL) && wr_data[CTL_SRST_BIT];
    assign r_pin  = rd_en && (8'(reg_addr) == ADR_PIN);

    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && !irq_oe)); // R1

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
        w_dir |=> (pin_oe == $past(wr_data))); // R2

    AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (w_pin && !w_srst) |=> (pin_out == $past(wr_data))); // R3

    AST_IRQ_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> ($past(ien_q & ~dir_q) != '0)); // R6

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (latch_q && pend_vec != '0 && !r_pin && !wr_en) |=> (pend_vec != '0)); // R7

    AST_DIR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        w_dir |=> (pend_vec == '0 || pin_s != $past(pin_s))); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        w_srst |=> (pin_oe == '0 && pin_out == '0 && !irq_oe && !latch_q)); // R9
endmodule

bind gpio_change_irq gpio_change_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_oe   (irq_oe),
    .dir_q    (dir_q),
    .ien_q    (ien_q),
    .latch_q  (latch_q),
    .pin_s    (pin_s),
    .pend_vec (pend_vec)
);

// File: tb/test_gpio_change_irq.sv
`timescale 1ns/1ps
module test_gpio_change_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_change_irq i_gpio_change_irq (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin_oe after reset", pin_oe, 8'h00);
        chk("R1 irq_oe after reset", {7'd0, irq_oe}, 8'h00);
        rd(4'hA, d); chk("R1 direction reads 0", d, 8'h00);
        rd(4'hC, d); chk("R1 enable reads 0", d, 8'h00);
        rd(4'hE, d); chk("R1 control reads 0", d, 8'h00);
    endtask

    task automatic t_dir_out();
        logic [7:0] d;
        drive_pins(8'h0F);
        wr(4'hA, 8'hA5);
        chk("R2 pin_oe follows direction", pin_oe, 8'hA5);
        rd(4'hA, d); chk("R2 direction read back", d, 8'hA5);
        wr(4'hB, 8'h3C);
        chk("R3 pin_out follows write", pin_out, 8'h3C);
        cyc(2);
        rd(4'hB, d); chk("R3 mixed pin-state read", d, (8'h3C & 8'hA5) | (8'h0F & ~8'hA5));
        wr(4'hA, 8'h00);
    endtask

    task automatic t_sync();
        drive_pins(8'h00);
        cyc(4);
        reg_addr = 4'hB;
        pin_in = 8'h81;
        @(negedge clk);
        chk("R11 not visible after one edge", rd_data, 8'h00);
        @(negedge clk);
        chk("R11 visible after two edges", rd_data, 8'h81);
    endtask

    task automatic t_live();
        logic [7:0] d;
        drive_pins(8'h00);
        cyc(4);
        wr(4'hE, 8'h00);
        wr(4'hC, 8'h01);
        drive_pins(8'h01); cyc(4);
        chk("R4 change raises irq", {7'd0, irq_oe}, 8'h01);
        drive_pins(8'h00); cyc(4);
        chk("R4 revert releases irq", {7'd0, irq_oe}, 8'h00);
        drive_pins(8'h01); cyc(4);
        chk("R4 second change raises irq", {7'd0, irq_oe}, 8'h01);
        rd(4'hB, d); chk("R5 read returns live level", d, 8'h01);
        cyc(3);
        chk("R5 read releases irq", {7'd0, irq_oe}, 8'h00);
        cyc(5);
        chk("R5 irq stays released", {7'd0, irq_oe}, 8'h00);
    endtask

    task automatic t_mask();
        drive_pins(8'h03); cyc(4);
        chk("R6 unenabled pin does not interrupt", {7'd0, irq_oe}, 8'h00);
        wr(4'hA, 8'h01);
        drive_pins(8'h02); cyc(4);
        chk("R6 output pin does not interrupt", {7'd0, irq_oe}, 8'h00);
        wr(4'hA, 8'h00);
        drive_pins(8'h00); cyc(3);
        wr(4'hA, 8'h00);
        cyc(3);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        drive_pins(8'h00); cyc(4);
        rd(4'hB, d);
        wr(4'hE, 8'h01);
        wr(4'hC, 8'h10);
        drive_pins(8'h10); cyc(4);
        drive_pins(8'h00); cyc(4);
        chk("R7 irq held after revert", {7'd0, irq_oe}, 8'h01);
        rd(4'hB, d); chk("R7 read returns captured level", d, 8'h10);
        cyc(3);
        chk("R7 read releases irq", {7'd0, irq_oe}, 8'h00);
        rd(4'hB, d); chk("R7 next read returns live level", d, 8'h00);
        wr(4'hE, 8'h00);
    endtask

    task automatic t_dirclr();
        wr(4'hC, 8'h01);
        drive_pins(8'h01); cyc(4);
        chk("R8 precondition irq raised", {7'd0, irq_oe}, 8'h01);
        wr(4'hA, 8'h00);
        cyc(3);
        chk("R8 direction write releases irq", {7'd0, irq_oe}, 8'h00);
    endtask

    task automatic t_srst();
        logic [7:0] d;
        wr(4'hA, 8'hFF); wr(4'hB, 8'hAA); wr(4'hC, 8'hFF); wr(4'hE, 8'h01);
        wr(4'hE, 8'h08);
        chk("R9 pin_oe cleared", pin_oe, 8'h00);
        chk("R9 pin_out cleared", pin_out, 8'h00);
        chk("R9 irq released", {7'd0, irq_oe}, 8'h00);
        rd(4'hA, d); chk("R9 direction cleared", d, 8'h00);
        rd(4'hC, d); chk("R9 enable cleared", d, 8'h00);
        rd(4'hE, d); chk("R9 control and bit 3 read 0", d, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(4'hA, 8'h5A);
        wr(4'hD, 8'hFF); wr(4'h0, 8'hFF); wr(4'hF, 8'hFF); wr(4'h9, 8'hFF);
        rd(4'hD, d); chk("R10 address 0x0D reads 0", d, 8'h00);
        rd(4'h0, d); chk("R10 address 0x00 reads 0", d, 8'h00);
        rd(4'hF, d); chk("R10 address 0x0F reads 0", d, 8'h00);
        rd(4'hA, d); chk("R10 direction untouched", d, 8'h5A);
        chk("R10 pin_out untouched", pin_out, 8'h00);
        wr(4'hE, 8'hF7);
        rd(4'hE, d); chk("R10 reserved control bits read 0", d, 8'h01);
        wr(4'hE, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_sync();
        t_live();
        t_mask();
        t_latch();
        t_dirclr();
        t_srst();
        t_reserved();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule